// File: doc/BRIEF.md
# GPIO Interrupt Detector with Status and Enable Bitmaps

This block watches a bank of general-purpose input pins and turns selected changes or levels on them into interrupt requests. Each pin carries two configuration bits, a trigger-kind bit and a polarity bit, which together choose one of four detection modes: rising edge, falling edge, active-low level or active-high level. A detected event sets that pin's bit in a sticky status bitmap. Software clears a status bit by writing a one to it.

An enable bitmap masks the status bitmap. The OR of every unmasked pending bit, registered once, drives a single interrupt line. Pin levels arrive already synchronized. Detection for a pin runs only while a per-pin sense qualifier is high; that qualifier stands for "pin in GPIO mode with input sensing on".

Status and enable are each seen on a simple register bus as a row of 32-bit words. The top address bit selects status (0) or enable (1), and the low bits select the word.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every status and enable bit reads 0 and `irq_out` is 0.
- R2: Trigger bit 0 with polarity bit 0 sets the pin's status bit on a 0-to-1 change of its level, and not on a 1-to-0 change. The bit is visible at the edge after the edge at which the new level is sampled.
- R3: Trigger bit 0 with polarity bit 1 sets the status bit on a 1-to-0 change, and not on a 0-to-1 change.
- R4: Trigger bit 1 with polarity bit 0 sets the status bit on every cycle the level is 0, so a clear while the level is 0 does not last; after the level returns to 1 a clear holds.
- R5: Trigger bit 1 with polarity bit 1 sets the status bit on every cycle the level is 1.
- R6: Writing a word of the status bank clears each bit written as 1 and leaves each bit written as 0 unchanged. If a detection falls in the same cycle as the clear of that bit, the bit stays set.
- R7: A write to the enable bank stores the word, and the enable bank is unchanged without a write. `irq_out` equals the OR over all pins of status AND enable, delayed by one clock.
- R8: A pin whose `sense_en` bit is 0 never gets a status bit set. Bit positions at or above `NUM_PINS` read 0 in both banks, even after a write of ones.
- R9: `bus_addr[2]` selects the bank (0 status, 1 enable) and `bus_addr[1:0]` selects the word. Pin p lies at word p/32, bit p%32. Word index 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | NUM_PINS | Synchronized pin levels |
| trig_level | input | NUM_PINS | Per-pin trigger kind: 0 edge, 1 level |
| trig_inv | input | NUM_PINS | Per-pin polarity bit |
| sense_en | input | NUM_PINS | Per-pin detection qualifier |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Bank select (MSB) and word index |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Aggregated interrupt request |

## Verification
The bench builds the block with its defaults: 95 pins and 32-bit words. With these values the third word is filled only up to bit 30 and the fourth word index lies outside the bank. The unused bit 31 and the out-of-range word are therefore both reachable from the bus. The default width also puts pins in every word, so the bench can place stimulus in all three words and confirm the bit positions.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NUM_PINS = 95,
  parameter int WORD_W = 32,
  localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_level,
  input  logic [NUM_PINS-1:0] trig_level,
  input  logic [NUM_PINS-1:0] trig_inv,
  input  logic [NUM_PINS-1:0] sense_en,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  output logic                irq_out
);
  localparam int PAD_W = NUM_WORDS * WORD_W;

  logic [NUM_PINS-1:0] prev_q, status_q, enable_q;
  logic [NUM_PINS-1:0] rise, fall, hit, clr, en_d;
  logic                armed_q, irq_q;
  logic                bank;
  logic [IDX_W-1:0]    idx;
  logic [PAD_W-1:0]    sel_mask, wr_vec, stat_pad, en_pad, rd_pad;

  assign bank = bus_addr[ADDR_W-1];
  assign idx  = bus_addr[IDX_W-1:0];

  assign sel_mask = PAD_W'({WORD_W{1'b1}}) << (idx * WORD_W);
  assign wr_vec   = PAD_W'(bus_wdata) << (idx * WORD_W);
  assign stat_pad = PAD_W'(status_q);
  assign en_pad   = PAD_W'(enable_q);
  assign rd_pad   = (bank ? en_pad : stat_pad) >> (idx * WORD_W);
  assign bus_rdata = rd_pad[WORD_W-1:0];

  assign rise = armed_q ? (pin_level & ~prev_q) : '0;
  assign fall = armed_q ? (~pin_level & prev_q) : '0;

  assign hit = sense_en & ( ( trig_level &  trig_inv &  pin_level)
                          | ( trig_level & ~trig_inv & ~pin_level)
                          | (~trig_level & ~trig_inv &  rise)
                          | (~trig_level &  trig_inv &  fall));

  assign clr  = (bus_wr && !bank) ? NUM_PINS'(wr_vec & sel_mask) : '0;
  assign en_d = NUM_PINS'((en_pad & ~sel_mask) | (wr_vec & sel_mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      armed_q  <= 1'b0;
      status_q <= '0;
      enable_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      prev_q   <= pin_level;
      armed_q  <= 1'b1;
      status_q <= (status_q & ~clr) | hit;
      if (bus_wr && bank) enable_q <= en_d;
      irq_q    <= |(status_q & enable_q);
    end
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int NUM_PINS = 95,
  parameter int WORD_W = 32,
  localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int ADDR_W = IDX_W + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] pin_level,
  input logic [NUM_PINS-1:0] trig_level,
  input logic [NUM_PINS-1:0] trig_inv,
  input logic [NUM_PINS-1:0] sense_en,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                irq_out,
  input logic [NUM_PINS-1:0] status_q,
  input logic [NUM_PINS-1:0] enable_q
);
  logic [NUM_PINS-1:0] hi_act, lo_act;
  assign hi_act = sense_en & trig_level & trig_inv & pin_level;
  assign lo_act = sense_en & trig_level & ~trig_inv & ~pin_level;

  assert_level_low_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(lo_act)) == $past(lo_act)));

  assert_level_high_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(hi_act)) == $past(hi_act)));

  assert_clear_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && !bus_addr[ADDR_W-1]) |=> ((~status_q & $past(status_q)) == '0));

  assert_irq_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(|(status_q & enable_q))));

  assert_enable_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(enable_q));

  assert_no_set_unsensed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(sense_en)) == '0));
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .trig_level(trig_level),
  .trig_inv(trig_inv), .sense_en(sense_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .irq_out(irq_out), .status_q(status_q), .enable_q(enable_q)
);

// File: tb/gpio_irq_detect_test.sv
`timescale 1ns/1ps
module gpio_irq_detect_test;
  localparam int NP = 95;
  localparam int WW = 32;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pin_level, trig_level, trig_inv, sense_en;
  logic          bus_wr;
  logic [2:0]    bus_addr;
  logic [WW-1:0] bus_wdata, bus_rdata;
  logic          irq_out;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_detect #(.NUM_PINS(NP), .WORD_W(WW)) uut (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .trig_level(trig_level),
    .trig_inv(trig_inv), .sense_en(sense_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  function automatic void expect_item(bit is_irq, logic [31:0] exp, string tag);
    item_t it;
    it.is_irq = is_irq;
    it.exp = exp;
    it.tag = tag;
    q.push_back(it);
  endfunction

  task automatic chk_rd(logic [2:0] addr, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_addr = addr;
    expect_item(1'b0, exp, tag);
  endtask

  task automatic chk_irq(logic exp, string tag);
    @(negedge clk);
    expect_item(1'b1, {31'b0, exp}, tag);
  endtask

  task automatic wr(logic [2:0] addr, logic [31:0] data, logic [31:0] readback, string tag);
    @(negedge clk);
    bus_wr = 1'b1;
    bus_addr = addr;
    bus_wdata = data;
    expect_item(1'b0, readback, tag);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  initial begin
    item_t it;
    logic [31:0] got;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        got = it.is_irq ? {31'b0, irq_out} : bus_rdata;
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pin_level = '0; trig_level = '0; trig_inv = '0; sense_en = '0;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int w = 0; w < 3; w++) begin
      chk_rd(3'(w), 32'h0, "R1 status after reset");
      chk_rd(3'(4 + w), 32'h0, "R1 enable after reset");
    end
    chk_irq(1'b0, "R1 irq after reset");

    @(negedge clk) sense_en = '1;
    @(negedge clk);

    // R2 rising edge
    @(negedge clk) pin_level[5] = 1'b1;
    chk_rd(3'd0, 32'h0000_0020, "R2 rising sets bit 5");
    wr(3'd0, 32'hFFFF_FFFF, 32'h0, "R6 write ones clears");
    @(negedge clk) pin_level[5] = 1'b0;
    chk_rd(3'd0, 32'h0, "R2 falling ignored in rising mode");

    // R3 falling edge, pin 40 = word 1 bit 8
    @(negedge clk) begin trig_inv[40] = 1'b1; pin_level[40] = 1'b1; end
    chk_rd(3'd1, 32'h0, "R3 rising ignored in falling mode");
    @(negedge clk) pin_level[40] = 1'b0;
    chk_rd(3'd1, 32'h0000_0100, "R3 falling sets word1 bit8 (R9)");
    wr(3'd1, 32'h0, 32'h0000_0100, "R6 write zero keeps");
    wr(3'd1, 32'h0000_0100, 32'h0, "R6 write one clears");

    // R5 level high, pin 70 = word 2 bit 6
    @(negedge clk) begin trig_level[70] = 1'b1; trig_inv[70] = 1'b1; end
    chk_rd(3'd2, 32'h0, "R5 inactive level");
    @(negedge clk) pin_level[70] = 1'b1;
    chk_rd(3'd2, 32'h0000_0040, "R5 high level sets");
    wr(3'd2, 32'h0000_0040, 32'h0000_0040, "R6 event wins over clear");
    @(negedge clk) pin_level[70] = 1'b0;
    wr(3'd2, 32'h0000_0040, 32'h0, "R5 clear after release");

    // R4 level low, pin 94 = word 2 bit 30
    @(negedge clk) trig_level[94] = 1'b1;
    chk_rd(3'd2, 32'h4000_0000, "R4 low level sets");
    wr(3'd2, 32'h4000_0000, 32'h4000_0000, "R4 clear while low does not last");
    @(negedge clk) pin_level[94] = 1'b1;
    wr(3'd2, 32'h4000_0000, 32'h0, "R4 clear after level high");
    chk_rd(3'd2, 32'h0, "R4 stays clear while high");

    // R8 sensing off, unused bits; R9 out-of-range word
    @(negedge clk) begin sense_en[10] = 1'b0; pin_level[10] = 1'b1; end
    chk_rd(3'd0, 32'h0, "R8 no detect when sense off");
    chk_rd(3'd3, 32'h0, "R9 status word 3 reads 0");
    wr(3'd6, 32'hFFFF_FFFF, 32'h7FFF_FFFF, "R8 bit 95 reads 0");
    wr(3'd7, 32'hFFFF_FFFF, 32'h0, "R9 enable word 3 ignores write");

    // R7 masking and aggregation
    wr(3'd4, 32'h0000_0020, 32'h0000_0020, "R7 enable word0 stored");
    chk_irq(1'b0, "R7 irq idle");
    @(negedge clk) pin_level[3] = 1'b1;
    chk_rd(3'd0, 32'h0000_0008, "R7 masked status bit 3");
    chk_irq(1'b0, "R7 masked pin gives no irq");
    @(negedge clk) begin pin_level[5] = 1'b1; expect_item(1'b1, 32'h0, "R7 irq one-cycle latency"); end
    chk_rd(3'd0, 32'h0000_0028, "R2 second rising on pin 5");
    chk_irq(1'b1, "R7 irq asserted");
    wr(3'd4, 32'h0, 32'h0, "R7 enable cleared");
    chk_irq(1'b0, "R7 irq drops after disable");
    chk_rd(3'd6, 32'h7FFF_FFFF, "R7 enable word2 unchanged");

    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule